// File: doc/BRIEF.md
# DDR Width-Converting Data Path

This block sits between a 16-bit host data port and an 8-bit double-data-rate memory data port. It takes its cue from the state code of an external command sequencer and does not use handshakes of its own. While the sequencer is in its write-data state, each host word is split into two bytes: the low byte goes out on the rising half of the cycle and the high byte on the falling half. The memory data bus is driven only in that case. While the sequencer is in its read-data state, the byte captured on the rising edge and the byte captured on the falling edge are merged into one host word. That word is presented with a single-cycle valid pulse.

The double-rate side is modelled as a pair of byte lanes per clock cycle: a rising lane and a falling lane. The output lanes and the output enable feed the I/O cells, which are outside this block. A burst moves `BURST_LEN/2` host words back to back. A last flag marks the final word of each burst, in both directions.

Top module: `ddr_dp_width_conv`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `mem_oe_o`, `rd_valid_o`, `rd_last_o` and `wr_last_o` are 0, and both memory output lanes are 0.
- R2: The command state codes are IDLE=0, ACTIVATE=1, READ-CMD=2, CAS-WAIT=3, READ-DATA=4, WRITE-CMD=5, WRITE-DATA=6 and WRITE-RECOVER=7. Take a clock edge at which `cmd_state_i` is 6 (WRITE-DATA). In the following cycle, `mem_dq_rise_o` equals host word bits [7:0] and `mem_dq_fall_o` equals bits [15:8].
- R3: `mem_oe_o` is 1 in the cycle after an edge at which `cmd_state_i` is 6, and 0 after an edge at which it holds any other code.
- R4: Whenever `mem_oe_o` is 0, both memory output lanes are 0.
- R5: Take an edge at which `cmd_state_i` is 4 (READ-DATA). In the following cycle, `rd_valid_o` is 1 and `rd_data_o` = {falling-edge byte, rising-edge byte} as sampled at that edge.
- R6: After an edge at which `cmd_state_i` is not 4, `rd_valid_o` is 0 and `rd_data_o` keeps its previous value, whatever the memory lanes carry.
- R7: During consecutive WRITE-DATA cycles, `wr_last_o` is 1 alongside every `BURST_LEN/2`-th word (the 4th with the default of 8) and 0 otherwise. The count wraps, so the next word starts a new burst.
- R8: During consecutive READ-DATA cycles, `rd_last_o` is 1 together with `rd_valid_o` on every `BURST_LEN/2`-th word, and it is never 1 without `rd_valid_o`.
- R9: Leaving a data state restarts that direction's word count. A burst cut short leaves no partial count behind, so the next burst's last flag falls on its own `BURST_LEN/2`-th word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_state_i | input | 3 | Command sequencer state code |
| host_wdata_i | input | 16 | Host write word for the current write-data cycle |
| mem_dq_rise_i | input | 8 | Byte captured from memory on the rising edge |
| mem_dq_fall_i | input | 8 | Byte captured from memory on the falling edge |
| mem_dq_rise_o | output | 8 | Byte driven to memory on the rising half |
| mem_dq_fall_o | output | 8 | Byte driven to memory on the falling half |
| mem_oe_o | output | 1 | Output enable of the bidirectional memory data bus |
| wr_last_o | output | 1 | Marks the last word of a write burst on the lanes |
| rd_data_o | output | 16 | Reassembled host read word |
| rd_valid_o | output | 1 | One-cycle valid for `rd_data_o` |
| rd_last_o | output | 1 | Marks the last word of a read burst |

## Verification
Every output is one register away from its inputs, so any wrong internal state shows at the ports one cycle after the edge that caused it. A swapped byte order shows up as exchanged lanes or as halves of `rd_data_o` in their wrong places. A direction decode error shows up as an output enable or a valid pulse that appears in, or is missing from, a non-matching state. A beat counter that is off by one, or that is not cleared, moves the last flag away from the `BURST_LEN/2`-th word. That fault is seen no later than the end of the first burst, and the shortened-burst case exposes it within two bursts.

// File: rtl/ddr_dp_pkg.sv
package ddr_dp_pkg;
  localparam int STATE_W = 3;
  localparam logic [STATE_W-1:0] ST_IDLE   = 3'd0;
  localparam logic [STATE_W-1:0] ST_ACT    = 3'd1;
  localparam logic [STATE_W-1:0] ST_RDCMD  = 3'd2;
  localparam logic [STATE_W-1:0] ST_CASW   = 3'd3;
  localparam logic [STATE_W-1:0] ST_RDATA  = 3'd4;
  localparam logic [STATE_W-1:0] ST_WRCMD  = 3'd5;
  localparam logic [STATE_W-1:0] ST_WDATA  = 3'd6;
  localparam logic [STATE_W-1:0] ST_WRREC  = 3'd7;
endpackage

// File: rtl/ddr_dp_beat_ctr.sv
module ddr_dp_beat_ctr #(
  parameter int WORDS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic last_o
);
  localparam int CW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [CW-1:0] TOP = CW'(WORDS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (cnt == TOP) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign last_o = en && (cnt == TOP);
endmodule

// File: rtl/ddr_dp_wr_lane.sv
module ddr_dp_wr_lane #(
  parameter int MEM_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [2*MEM_W-1:0] word_i,
  input  logic               last_i,
  output logic [MEM_W-1:0]   rise_o,
  output logic [MEM_W-1:0]   fall_o,
  output logic               oe_o,
  output logic               last_o
);
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      rise_o <= '0;
      fall_o <= '0;
      oe_o   <= 1'b0;
      last_o <= 1'b0;
    end else begin
      rise_o <= word_i[MEM_W-1:0];
      fall_o <= word_i[2*MEM_W-1:MEM_W];
      oe_o   <= 1'b1;
      last_o <= last_i;
    end
  end
endmodule

// File: rtl/ddr_dp_rd_lane.sv
module ddr_dp_rd_lane #(
  parameter int MEM_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [MEM_W-1:0]   rise_i,
  input  logic [MEM_W-1:0]   fall_i,
  input  logic               last_i,
  output logic [2*MEM_W-1:0] word_o,
  output logic               valid_o,
  output logic               last_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_o  <= '0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end else begin
      valid_o <= en;
      last_o  <= en && last_i;
      if (en) word_o <= {fall_i, rise_i};
    end
  end
endmodule

// File: rtl/ddr_dp_width_conv.sv
module ddr_dp_width_conv
  import ddr_dp_pkg::*;
#(
  parameter int MEM_W     = 8,
  parameter int BURST_LEN = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         cmd_state_i,
  input  logic [2*MEM_W-1:0] host_wdata_i,
  input  logic [MEM_W-1:0]   mem_dq_rise_i,
  input  logic [MEM_W-1:0]   mem_dq_fall_i,
  output logic [MEM_W-1:0]   mem_dq_rise_o,
  output logic [MEM_W-1:0]   mem_dq_fall_o,
  output logic               mem_oe_o,
  output logic               wr_last_o,
  output logic [2*MEM_W-1:0] rd_data_o,
  output logic               rd_valid_o,
  output logic               rd_last_o
);
  localparam int WORDS = (BURST_LEN / 2 > 0) ? BURST_LEN / 2 : 1;

  logic wr_en, rd_en, wr_last_c, rd_last_c;

  assign wr_en = (cmd_state_i == ST_WDATA);
  assign rd_en = (cmd_state_i == ST_RDATA);

  ddr_dp_beat_ctr #(.WORDS(WORDS)) u_wr_ctr (
    .clk(clk), .rst(rst), .en(wr_en), .last_o(wr_last_c)
  );

  ddr_dp_beat_ctr #(.WORDS(WORDS)) u_rd_ctr (
    .clk(clk), .rst(rst), .en(rd_en), .last_o(rd_last_c)
  );

  ddr_dp_wr_lane #(.MEM_W(MEM_W)) u_wr (
    .clk(clk), .rst(rst), .en(wr_en), .word_i(host_wdata_i), .last_i(wr_last_c),
    .rise_o(mem_dq_rise_o), .fall_o(mem_dq_fall_o), .oe_o(mem_oe_o), .last_o(wr_last_o)
  );

  ddr_dp_rd_lane #(.MEM_W(MEM_W)) u_rd (
    .clk(clk), .rst(rst), .en(rd_en), .rise_i(mem_dq_rise_i), .fall_i(mem_dq_fall_i),
    .last_i(rd_last_c), .word_o(rd_data_o), .valid_o(rd_valid_o), .last_o(rd_last_o)
  );
endmodule

// File: rtl/ddr_dp_width_conv_chk.sv
module ddr_dp_width_conv_chk #(
  parameter int MEM_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [2:0]         cmd_state_i,
  input logic [2*MEM_W-1:0] host_wdata_i,
  input logic [MEM_W-1:0]   mem_dq_rise_i,
  input logic [MEM_W-1:0]   mem_dq_fall_i,
  input logic [MEM_W-1:0]   mem_dq_rise_o,
  input logic [MEM_W-1:0]   mem_dq_fall_o,
  input logic               mem_oe_o,
  input logic [2*MEM_W-1:0] rd_data_o,
  input logic               rd_valid_o,
  input logic               rd_last_o
);
  AST_WR_SPLIT: assert property (@(posedge clk) disable iff (rst)
    (cmd_state_i == 3'd6) |=> (mem_dq_rise_o == $past(host_wdata_i[MEM_W-1:0]) &&
                               mem_dq_fall_o == $past(host_wdata_i[2*MEM_W-1:MEM_W]))); // R2
  AST_OE_ON: assert property (@(posedge clk) disable iff (rst)
    (cmd_state_i == 3'd6) |=> mem_oe_o); // R3
  AST_OE_OFF: assert property (@(posedge clk) disable iff (rst)
    (cmd_state_i != 3'd6) |=> !mem_oe_o); // R3
  AST_IDLE_LANES_ZERO: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_o |-> (mem_dq_rise_o == '0 && mem_dq_fall_o == '0)); // R4
  AST_RD_MERGE: assert property (@(posedge clk) disable iff (rst)
    (cmd_state_i == 3'd4) |=> (rd_valid_o && rd_data_o == {$past(mem_dq_fall_i), $past(mem_dq_rise_i)})); // R5
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cmd_state_i != 3'd4) |=> (!rd_valid_o && $stable(rd_data_o))); // R6
  AST_RD_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    rd_last_o |-> rd_valid_o); // R8
endmodule

bind ddr_dp_width_conv ddr_dp_width_conv_chk #(.MEM_W(MEM_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_state_i(cmd_state_i), .host_wdata_i(host_wdata_i),
  .mem_dq_rise_i(mem_dq_rise_i), .mem_dq_fall_i(mem_dq_fall_i),
  .mem_dq_rise_o(mem_dq_rise_o), .mem_dq_fall_o(mem_dq_fall_o), .mem_oe_o(mem_oe_o),
  .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .rd_last_o(rd_last_o)
);

// File: tb/sim_ddr_dp_width_conv.sv
module sim_ddr_dp_width_conv;
  localparam int CLK_P = 10;
  localparam int WORDS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cmd_state = 3'd0;
  logic [15:0] wdata = '0;
  logic [7:0]  dq_ri = '0, dq_fi = '0;
  logic [7:0]  dq_ro, dq_fo;
  logic        oe, wr_last, rd_valid, rd_last;
  logic [15:0] rd_data;

  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  ddr_dp_width_conv u0 (
    .clk(clk), .rst(rst), .cmd_state_i(cmd_state), .host_wdata_i(wdata),
    .mem_dq_rise_i(dq_ri), .mem_dq_fall_i(dq_fi), .mem_dq_rise_o(dq_ro),
    .mem_dq_fall_o(dq_fo), .mem_oe_o(oe), .wr_last_o(wr_last),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .rd_last_o(rd_last)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1; cmd_state = 3'd6; wdata = 16'hBEEF; dq_ri = 8'h11; dq_fi = 8'h22;
    tick(); tick();
    chk(oe == 0, "R1 oe in reset", 32'(oe), 0);
    chk(rd_valid == 0 && rd_last == 0 && wr_last == 0, "R1 flags in reset",
        {29'd0, rd_valid, rd_last, wr_last}, 0);
    chk(dq_ro == 0 && dq_fo == 0, "R1 lanes in reset", {16'd0, dq_fo, dq_ro}, 0);
    cmd_state = 3'd0;
    rst = 1'b0;
    tick();
    chk(oe == 0 && rd_valid == 0, "R1 first cycle after reset", {30'd0, oe, rd_valid}, 0);
  endtask

  task automatic t_write_burst(input int n, input logic [15:0] base);
    for (int i = 0; i < n; i++) begin
      logic [15:0] w;
      w = base + 16'(i) * 16'h0111;
      cmd_state = 3'd6; wdata = w;
      tick();
      chk(dq_ro == w[7:0], "R2 rising lane low byte", 32'(dq_ro), 32'(w[7:0]));
      chk(dq_fo == w[15:8], "R2 falling lane high byte", 32'(dq_fo), 32'(w[15:8]));
      chk(oe == 1, "R3 oe in write data", 32'(oe), 1);
      chk(wr_last == ((i % WORDS) == WORDS-1), "R7 write last flag",
          32'(wr_last), 32'((i % WORDS) == WORDS-1));
    end
    cmd_state = 3'd7; wdata = 16'hFFFF;
    tick();
    chk(oe == 0, "R3 oe off after write", 32'(oe), 0);
    chk(dq_ro == 0 && dq_fo == 0, "R4 lanes zero when not driving", {16'd0, dq_fo, dq_ro}, 0);
  endtask

  task automatic t_state_sweep();
    for (int s = 0; s < 8; s++) begin
      if (s == 6) continue;
      cmd_state = 3'(s); wdata = 16'h5AA5;
      tick();
      chk(oe == 0, "R3 oe off for other state", 32'(oe), 0);
      chk(dq_ro == 0 && dq_fo == 0, "R4 lanes zero for other state", {16'd0, dq_fo, dq_ro}, 0);
    end
  endtask

  task automatic t_read_burst(input int n, input logic [7:0] seed);
    logic [15:0] last_w;
    last_w = 16'h0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] r, f;
      r = seed + 8'(2*i);
      f = ~(seed + 8'(2*i + 1));
      cmd_state = 3'd4; dq_ri = r; dq_fi = f;
      tick();
      last_w = {f, r};
      chk(rd_valid == 1, "R5 read valid pulse", 32'(rd_valid), 1);
      chk(rd_data == {f, r}, "R5 read word merge", 32'(rd_data), 32'({f, r}));
      chk(rd_last == ((i % WORDS) == WORDS-1), "R8 read last flag",
          32'(rd_last), 32'((i % WORDS) == WORDS-1));
    end
    cmd_state = 3'd3; dq_ri = 8'hC3; dq_fi = 8'h3C;
    tick();
    chk(rd_valid == 0, "R6 no valid outside read data", 32'(rd_valid), 0);
    chk(rd_data == last_w, "R6 read word held", 32'(rd_data), 32'(last_w));
    chk(rd_last == 0, "R8 no last without valid", 32'(rd_last), 0);
    cmd_state = 3'd6; dq_ri = 8'h99; dq_fi = 8'h66;
    tick();
    chk(rd_valid == 0 && rd_data == last_w, "R6 write state ignores read lanes",
        32'(rd_data), 32'(last_w));
    cmd_state = 3'd0;
    tick();
  endtask

  task automatic t_cut_burst();
    // R9: two write words, pause, then a fresh burst
    t_write_burst(2, 16'h1200);
    t_write_burst(WORDS, 16'h3400);
    // R9: three read words, pause, then a fresh burst
    t_read_burst(3, 8'h40);
    t_read_burst(WORDS, 8'h70);
    // R9: write right after read restarts the count
    t_read_burst(1, 8'h10);
    t_write_burst(WORDS, 16'h5600);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_write_burst(WORDS, 16'hA0B1);
        t_write_burst(2*WORDS, 16'h0102);
        t_state_sweep();
        t_read_burst(WORDS, 8'h21);
        t_read_burst(2*WORDS, 8'hE0);
        t_cut_burst();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule